// File: doc/BRIEF.md
# Command Ring Fetch Engine

This block is the controller half of an outbound command ring. Software keeps a 256-slot ring of 32-bit command words in memory. It places a new word one slot past the current write index and then publishes that slot as the new write index. The engine compares its own read index with the published write index. For each outstanding slot it reads the word through a one-cycle-latency memory port and offers it to a link transmitter over a valid/ready handshake. The read index moves forward only once the transmitter has taken the word.

Software controls the engine through four 16-bit registers on a small write/read port: control/status, write index, read index, and ring size. A run bit starts and stops fetching. The read index has a two-phase reset: software raises a flag, waits to see it acknowledged, then drops it and waits to see the register read back as zero. A full indication lets software see when only the one slot that must stay empty remains free.

Top module: `cmdring_fetch`

## Requirements
- R1: After reset, the registers read as follows: control 0x0000, write index 0x0000, read index 0x0000, size 0x0040. `cmdValid` and `memRdEn` are low.
- R2: Each fetch reads slot (read index + 1) mod 256. The engine consumes slots up to and including the write index, then stops fetching.
- R3: Once `cmdValid` rises, it stays high and `cmdData` stays unchanged until `cmdReady` is sampled high. The read index advances by one only on that acceptance.
- R4: `cmdCodec` always equals bits 31:28 of `cmdData`.
- R5: Writing 1 to bit 15 of the read index register (address 2) starts a reset. Within two cycles the register reads 0x8000. Writing 0 releases the reset, and the register then reads 0x0000. No fetch or offer takes place while the reset flag is set or acknowledged.
- R6: Bit 0 of a control write (address 0) sets or clears the run request. Control bit 0 reads 1 while run is requested or a fetch is still in progress. After run is cleared, a word already being offered completes its handshake, control bit 0 then reads 0, no further fetch starts, and the read index keeps its value.
- R7: Control bit 1 reads 1 exactly when (write index + 1) mod 256 equals the read index.
- R8: The write index register (address 1) keeps only 8 bits. Writing 0xFFFF reads back 0x00FF, so an all-ones readback never occurs.
- R9: The size register (address 3) holds a 2-bit code in bits 1:0, and bits 7:4 read 0x4. Fetching is enabled only while the code is 0x2, which selects 256 entries. The code resets to 0.
- R10: The read index wraps from 255 to 0, and fetching continues across the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select: 0 control, 1 write index, 2 read index, 3 size |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Register read data for `regAddr` (combinational) |
| memRdEn | output | 1 | Ring memory read request |
| memAddr | output | 8 | Ring slot being read |
| memRdData | input | 32 | Slot contents, valid one cycle after the request |
| cmdValid | output | 1 | Command word offered to the transmitter |
| cmdReady | input | 1 | Transmitter accepts the offered word |
| cmdData | output | 32 | Offered command word |
| cmdCodec | output | 4 | Target codec address of the offered word |

## Verification
An internal fault shows at the ports within a few cycles. A read index that moves at the wrong time appears in the read index readback right after the handshake, or as a repeated or skipped word on the next offer. A wrong comparison between the indexes either leaves the engine fetching past the write index or stops it short. Either case is visible within one fetch, about three cycles. A state machine that ignores stop or reset requests keeps `memRdEn` or `cmdValid` active during windows in which both must stay low.

// File: rtl/cmdring_pkg.sv
package cmdring_pkg;
  localparam int REG_W = 16;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_WPTR = 2'd1;
  localparam logic [1:0] ADDR_RPTR = 2'd2;
  localparam logic [1:0] ADDR_SIZE = 2'd3;

  localparam int RUN_BIT  = 0;
  localparam int FULL_BIT = 1;
  localparam int PRST_BIT = REG_W - 1;

  localparam logic [1:0] SIZE_256 = 2'b10;
  localparam logic [3:0] SIZE_CAP = 4'b0100;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_OFFER} fetchState_t;

  typedef struct packed {
    logic memRead;
    logic capture;
    logic advance;
    logic clearPtr;
  } ringStrobe_t;
endpackage

// File: rtl/cmdring_dpath.sv
module cmdring_dpath
  import cmdring_pkg::*;
#(
  parameter int PTR_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ringStrobe_t       strobe,
  input  logic              wpWrite,
  input  logic              sizeWrite,
  input  logic [PTR_W-1:0]  wrBits,
  input  logic [DATA_W-1:0] memRdData,
  output logic [PTR_W-1:0]  rdPtr,
  output logic [PTR_W-1:0]  wrPtr,
  output logic [PTR_W-1:0]  fetchAddr,
  output logic [1:0]        sizeCode,
  output logic [DATA_W-1:0] cmdWord,
  output logic              pending,
  output logic              ringFull
);
  localparam logic [PTR_W-1:0] PTR_ONE = PTR_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr    <= '0;
      wrPtr    <= '0;
      sizeCode <= '0;
      cmdWord  <= '0;
    end else begin
      if (wpWrite)   wrPtr    <= wrBits;
      if (sizeWrite) sizeCode <= wrBits[1:0];
      if (strobe.clearPtr)     rdPtr <= '0;
      else if (strobe.advance) rdPtr <= rdPtr + PTR_ONE;
      if (strobe.capture) cmdWord <= memRdData;
    end
  end

  // slot index wraps naturally at 2**PTR_W
  assign fetchAddr = rdPtr + PTR_ONE;
  assign pending   = (rdPtr != wrPtr);
  assign ringFull  = ((wrPtr + PTR_ONE) == rdPtr);

  AST_PTR_MOVES_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (rdPtr != $past(rdPtr)) |-> $past(strobe.advance || strobe.clearPtr)); // R3
endmodule

// File: rtl/cmdring_ctrl.sv
module cmdring_ctrl
  import cmdring_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        ctrlWrite,
  input  logic        rpWrite,
  input  logic        runBit,
  input  logic        rstBit,
  input  logic        pending,
  input  logic        sizeOk,
  input  logic        cmdReady,
  output ringStrobe_t strobe,
  output logic        cmdValid,
  output logic        runActive,
  output logic        ptrRstAck
);
  fetchState_t state, nextState;
  logic runReq;
  logic rstReq;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      runReq    <= 1'b0;
      rstReq    <= 1'b0;
      ptrRstAck <= 1'b0;
    end else begin
      state <= nextState;
      if (ctrlWrite) runReq <= runBit;
      if (rpWrite)   rstReq <= rstBit;
      if (!rstReq)                ptrRstAck <= 1'b0;
      else if (state == ST_IDLE)  ptrRstAck <= 1'b1;
    end
  end

  always_comb begin
    strobe    = '0;
    nextState = state;
    cmdValid  = 1'b0;
    case (state)
      ST_IDLE: begin
        if (runReq && sizeOk && !rstReq && !ptrRstAck && pending) begin
          strobe.memRead = 1'b1;
          nextState      = ST_WAIT;
        end
      end
      ST_WAIT: begin
        strobe.capture = 1'b1;
        nextState      = ST_OFFER;
      end
      ST_OFFER: begin
        cmdValid = 1'b1;
        if (cmdReady) begin
          strobe.advance = 1'b1;
          nextState      = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
    strobe.clearPtr = rstReq && (state == ST_IDLE);
  end

  assign runActive = runReq || (state != ST_IDLE);

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.memRead, strobe.capture, strobe.advance})); // R3
  AST_STOP_AFTER_HANDSHAKE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(runActive) |-> $past(state == ST_IDLE) || $past(cmdValid && cmdReady)); // R6
endmodule

// File: rtl/cmdring_fetch.sv
module cmdring_fetch
  import cmdring_pkg::*;
#(
  parameter int PTR_W   = 8,
  parameter int DATA_W  = 32,
  parameter int CODEC_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  output logic              memRdEn,
  output logic [PTR_W-1:0]  memAddr,
  input  logic [DATA_W-1:0] memRdData,
  output logic              cmdValid,
  input  logic              cmdReady,
  output logic [DATA_W-1:0] cmdData,
  output logic [CODEC_W-1:0] cmdCodec
);
  ringStrobe_t       strobe;
  logic [PTR_W-1:0]  rdPtr, wrPtr, fetchAddr;
  logic [1:0]        sizeCode;
  logic [DATA_W-1:0] cmdWord;
  logic              pending, ringFull, runActive, ptrRstAck;
  logic              unusedWrBits;

  assign unusedWrBits = ^regWrData[REG_W-2:PTR_W];

  cmdring_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .ctrlWrite (regWrEn && regAddr == ADDR_CTRL),
    .rpWrite   (regWrEn && regAddr == ADDR_RPTR),
    .runBit    (regWrData[RUN_BIT]),
    .rstBit    (regWrData[PRST_BIT]),
    .pending   (pending),
    .sizeOk    (sizeCode == SIZE_256),
    .cmdReady  (cmdReady),
    .strobe    (strobe),
    .cmdValid  (cmdValid),
    .runActive (runActive),
    .ptrRstAck (ptrRstAck)
  );

  cmdring_dpath #(.PTR_W(PTR_W), .DATA_W(DATA_W)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wpWrite   (regWrEn && regAddr == ADDR_WPTR),
    .sizeWrite (regWrEn && regAddr == ADDR_SIZE),
    .wrBits    (regWrData[PTR_W-1:0]),
    .memRdData (memRdData),
    .rdPtr     (rdPtr),
    .wrPtr     (wrPtr),
    .fetchAddr (fetchAddr),
    .sizeCode  (sizeCode),
    .cmdWord   (cmdWord),
    .pending   (pending),
    .ringFull  (ringFull)
  );

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_CTRL: begin
        regRdData[RUN_BIT]  = runActive;
        regRdData[FULL_BIT] = ringFull;
      end
      ADDR_WPTR: regRdData[PTR_W-1:0] = wrPtr;
      ADDR_RPTR: begin
        regRdData[PTR_W-1:0] = rdPtr;
        regRdData[PRST_BIT]  = ptrRstAck;
      end
      default: begin
        regRdData[1:0] = sizeCode;
        regRdData[7:4] = SIZE_CAP;
      end
    endcase
  end

  assign memRdEn  = strobe.memRead;
  assign memAddr  = fetchAddr;
  assign cmdData  = cmdWord;
  assign cmdCodec = cmdWord[DATA_W-1 -: CODEC_W];

  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && !cmdReady |=> cmdValid && $stable(cmdData)); // R3
  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> rdPtr != wrPtr); // R2
  AST_QUIET_IN_PTR_RESET: assert property (@(posedge clk) disable iff (!rstN)
    ptrRstAck |-> !memRdEn && !cmdValid); // R5
endmodule

// File: tb/cmdring_fetch_tb.sv
module cmdring_fetch_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [15:0] regWrData = 16'h0;
  logic [15:0] regRdData;
  logic        memRdEn;
  logic [7:0]  memAddr;
  logic [31:0] memRdData = 32'h0;
  logic        cmdValid;
  logic        cmdReady = 1'b0;
  logic [31:0] cmdData;
  logic [3:0]  cmdCodec;

  int checks = 0;
  int errors = 0;
  logic [31:0] ringMem [256];

  always #5 clk = ~clk;

  cmdring_fetch u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .memRdEn(memRdEn),
    .memAddr(memAddr), .memRdData(memRdData), .cmdValid(cmdValid),
    .cmdReady(cmdReady), .cmdData(cmdData), .cmdCodec(cmdCodec)
  );

  always @(posedge clk) if (memRdEn) memRdData <= ringMem[memAddr];

  function automatic logic [31:0] cmdFor(input logic [7:0] i);
    return {i[3:0], 4'h5, 16'hC0DE ^ {8'h00, i}, i};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [1:0] a, output logic [15:0] v);
    regAddr = a;
    #1;
    v = regRdData;
  endtask

  task automatic quietWindow(input int n, input string req);
    int seen = 0;
    repeat (n) begin
      @(negedge clk);
      if (memRdEn || cmdValid) seen++;
    end
    chk(req, seen, 0);
  endtask

  task automatic takeCmd(input int idx, input string req);
    logic [7:0] k = idx[7:0];
    int waited = 0;
    while (!cmdValid && waited < 40) begin
      @(negedge clk);
      waited++;
    end
    chk({req, " valid"}, cmdValid, 1);
    chk({req, " data"}, cmdData, cmdFor(k));
    chk("R4 codec", {28'h0, cmdCodec}, {28'h0, k[3:0]});
    cmdReady = 1'b1;
    @(negedge clk);
    cmdReady = 1'b0;
  endtask

  task automatic testReset;
    logic [15:0] v;
    rdReg(2'd0, v); chk("R1 ctrl", v, 16'h0000);
    rdReg(2'd1, v); chk("R1 wptr", v, 16'h0000);
    rdReg(2'd2, v); chk("R1 rptr", v, 16'h0000);
    rdReg(2'd3, v); chk("R1 size", v, 16'h0040);
    chk("R1 outputs", {cmdValid, memRdEn}, 0);
  endtask

  task automatic testSizeGate;
    logic [15:0] v;
    wrReg(2'd1, 16'h0001);
    wrReg(2'd0, 16'h0001);
    quietWindow(10, "R9 no fetch with size code 0");
    rdReg(2'd2, v); chk("R9 rptr held", v, 16'h0000);
    wrReg(2'd3, 16'h0002);
    rdReg(2'd3, v); chk("R9 size readback", v, 16'h0042);
    takeCmd(1, "R9 fetch after size set");
    rdReg(2'd2, v); chk("R3 rptr after accept", v, 16'h0001);
  endtask

  task automatic testBurst;
    logic [15:0] v;
    wrReg(2'd1, 16'h0004);
    for (int i = 2; i <= 4; i++) takeCmd(i, "R2 burst");
    quietWindow(8, "R2 stops at write index");
    rdReg(2'd2, v); chk("R2 rptr equals wptr", v, 16'h0004);
  endtask

  task automatic testBackpressure;
    logic [15:0] v;
    int bad = 0;
    wrReg(2'd1, 16'h0005);
    for (int w = 0; w < 40 && !cmdValid; w++) @(negedge clk);
    repeat (6) begin
      @(negedge clk);
      if (!cmdValid || cmdData !== cmdFor(8'd5)) bad++;
      rdReg(2'd2, v);
      if (v !== 16'h0004) bad++;
    end
    chk("R3 held under backpressure", bad, 0);
    takeCmd(5, "R3 accept after stall");
    rdReg(2'd2, v); chk("R3 rptr after stall", v, 16'h0005);
  endtask

  task automatic testStop;
    logic [15:0] v;
    wrReg(2'd1, 16'h0007);
    for (int w = 0; w < 40 && !cmdValid; w++) @(negedge clk);
    wrReg(2'd0, 16'h0000);
    rdReg(2'd0, v); chk("R6 active while offering", {31'h0, v[0]}, 1);
    chk("R6 offer kept", cmdValid, 1);
    takeCmd(6, "R6 finish offered word");
    rdReg(2'd0, v); chk("R6 stopped", {31'h0, v[0]}, 0);
    quietWindow(10, "R6 no fetch after stop");
    rdReg(2'd2, v); chk("R6 rptr kept", v, 16'h0006);
    wrReg(2'd0, 16'h0001);
    takeCmd(7, "R6 resume");
    wrReg(2'd0, 16'h0000);
  endtask

  task automatic testFullAndMask;
    logic [15:0] v;
    wrReg(2'd1, 16'h0006);
    rdReg(2'd0, v); chk("R7 full flag set", v, 16'h0002);
    wrReg(2'd1, 16'h0007);
    rdReg(2'd0, v); chk("R7 full flag clear", v, 16'h0000);
    wrReg(2'd1, 16'hFFFF);
    rdReg(2'd1, v); chk("R8 wptr masked", v, 16'h00FF);
    wrReg(2'd1, 16'h0007);
  endtask

  task automatic testPtrReset;
    logic [15:0] v;
    wrReg(2'd2, 16'h8000);
    @(negedge clk);
    rdReg(2'd2, v); chk("R5 reset acknowledged", v, 16'h8000);
    wrReg(2'd1, 16'h0003);
    wrReg(2'd0, 16'h0001);
    quietWindow(10, "R5 no fetch during reset");
    wrReg(2'd2, 16'h0000);
    @(negedge clk);
    rdReg(2'd2, v); chk("R5 reset released", v, 16'h0000);
    for (int i = 1; i <= 3; i++) takeCmd(i, "R5 fetch from slot 1");
  endtask

  task automatic testWrap;
    logic [15:0] v;
    wrReg(2'd1, 16'h00FE);
    for (int i = 4; i <= 254; i++) takeCmd(i, "R10 run to end");
    wrReg(2'd1, 16'h0001);
    takeCmd(255, "R10 last slot");
    takeCmd(0, "R10 wrapped slot 0");
    takeCmd(1, "R10 wrapped slot 1");
    rdReg(2'd2, v); chk("R10 rptr after wrap", v, 16'h0001);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) ringMem[i] = cmdFor(i[7:0]);
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testSizeGate();
    testBurst();
    testBackpressure();
    testStop();
    testFullAndMask();
    testPtrReset();
    testWrap();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog all requirements actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule